// File: doc/BRIEF.md
# Overlapped Immediate Pair-Load Fetch Sequencer

This block sequences the fetch and execute of a small 8-bit core with exact cycle timing. It covers opcode fetch and one instruction: the load of a register pair from the two bytes that follow the opcode. Time is divided into machine cycles, and each machine cycle into T-states. Every T-state lasts two system clocks: a low phase, then a high phase. A phase bit that flips on every system clock tracks the phase.

The program counter is copied into an increment latch. The latch drives the 16-bit address bus. The incremented value goes back into the program counter later in the same machine cycle. The incoming bytes go into an instruction register during a fetch, or into a temporary register during a data read. The transfers that touch the program counter and the transfers that touch the registers sit on different phases, so they never meet.

The first data byte is written to the low register early in the third machine cycle. The write of the second byte to the high register is deferred into the opcode fetch of the next instruction, and runs while that fetch is in progress. Any other opcode takes a single fetch cycle and has no effect.

Top module: `imm_fetch_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `state_code` is 0, `pc_out` is 0, `addr_out` is 0, and `wr_lo` and `wr_hi` are low. The first fetch after reset therefore reads address 0.
- R2: `state_code` is laid out as follows: bits [4:3] hold the machine cycle (0 = opcode fetch, 1 = first data read, 2 = second data read), bits [2:1] hold the T-state minus one, and bit 0 holds the phase (0 = low, 1 = high). The phase flips on every clock, and the T-state advances after each high phase. A fetch has T-states T1 to T4. A data read has T-states T1 to T3.
- R3: After a fetch whose opcode equals `PAIR_OPC` (default 8'h11), the two data reads follow, and then a fetch. After a fetch of any other opcode, the next machine cycle is a fetch.
- R4: `addr_en` is high in both phases of T1 and nowhere else. During T1, `addr_out` holds the address of the current machine cycle: the program counter value at the end of the previous machine cycle.
- R5: The program counter rises by exactly one in every machine cycle. The new value is written on the T2 high phase and appears on `pc_out` from the T3 low phase.
- R6: `rd_en` is high from T1 through T3 of every machine cycle and low in T4.
- R7: During a fetch, `data_in` is sampled on the T3 low phase, and `ir_out` shows that byte in T4.
- R8: `wr_lo` pulses only in the T1 high phase of the second data read, with the first data byte on `wr_data`.
- R9: `wr_hi` pulses only in the T3 high phase of the fetch that follows a pair load, with the second data byte on `wr_data`. There is no such pulse after any other opcode, or in the first fetch after reset.
- R10: `wr_lo` and `wr_hi` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one phase per cycle |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Byte returned from memory |
| addr_out | output | 16 | Address from the increment latch |
| addr_en | output | 1 | Address bus driven (T1) |
| rd_en | output | 1 | Memory read strobe (T1 to T3) |
| pc_out | output | 16 | Current program counter |
| ir_out | output | 8 | Instruction register |
| wr_lo | output | 1 | Write strobe for the low register |
| wr_hi | output | 1 | Write strobe for the high register |
| wr_data | output | 8 | Byte passed through to the register file |
| state_code | output | 5 | {machine cycle, T-state minus one, phase} |

## Verification
The assertions check, on every clock, that the phase alternates and that the program counter only steps to the latched address plus one. They also check that the address holds steady through T1, that an address is always covered by a read strobe, that the two write strobes never overlap, and that each strobe lands only on its own state code. Only the bench scenarios can show the rest. These are the order of machine cycles for a pair-load opcode and for other opcodes, and which byte reaches the instruction register. They also cover the values carried by `wr_data` and the missing high write after a non-load opcode or after reset. The bench runs a mixed program that includes the all-zero and all-one data bytes, and then runs it again after a reset in the middle of a cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    MC_FETCH = 2'd0,
    MC_DATA1 = 2'd1,
    MC_DATA2 = 2'd2
  } mcyc_e;

  localparam int TIDX_W  = 2;
  localparam int STATE_W = 2 + TIDX_W + 1;

  // Index of the final T-state in a machine cycle (T4 for fetch, T3 otherwise)
  function automatic logic [TIDX_W-1:0] final_tidx(input mcyc_e mc);
    return (mc == MC_FETCH) ? TIDX_W'(3) : TIDX_W'(2);
  endfunction

  function automatic logic [STATE_W-1:0] pack_state(input mcyc_e mc,
                                                   input logic [TIDX_W-1:0] tix,
                                                   input logic ph);
    return {mc, tix, ph};
  endfunction

  // Pass-through path from temporary register to register file
  function automatic logic [7:0] alu_pass(input logic [7:0] v);
    return v;
  endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              is_pair,
  output mcyc_e             mc,
  output logic [TIDX_W-1:0] tix,
  output logic              ph,
  output logic              ev_t1,
  output logic              ev_t1_hi,
  output logic              ev_t2_hi,
  output logic              ev_t3_lo,
  output logic              ev_t3_hi,
  output logic              ev_last_hi,
  output logic              rd_window
);

  mcyc_e mc_next;
  logic  at_last;

  assign at_last = (tix == final_tidx(mc));

  always_comb begin
    case (mc)
      MC_FETCH: mc_next = is_pair ? MC_DATA1 : MC_FETCH;
      MC_DATA1: mc_next = MC_DATA2;
      default:  mc_next = MC_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mc  <= MC_FETCH;
      tix <= '0;
      ph  <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) begin
        if (at_last) begin
          tix <= '0;
          mc  <= mc_next;
        end else begin
          tix <= tix + TIDX_W'(1);
        end
      end
    end
  end

  assign ev_t1      = (tix == TIDX_W'(0));
  assign ev_t1_hi   = ev_t1 && ph;
  assign ev_t2_hi   = (tix == TIDX_W'(1)) && ph;
  assign ev_t3_lo   = (tix == TIDX_W'(2)) && !ph;
  assign ev_t3_hi   = (tix == TIDX_W'(2)) && ph;
  assign ev_last_hi = at_last && ph;
  assign rd_window  = (tix <= TIDX_W'(2));

endmodule

// File: rtl/addr_unit.sv
module addr_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_last_hi,
  input  logic          ev_t2_hi,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] inc_latch
);

  function automatic logic [AW-1:0] pc_step(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      inc_latch <= '0;
    end else begin
      if (ev_last_hi) inc_latch <= pc;
      if (ev_t2_hi)   pc        <= pc_step(inc_latch);
    end
  end

endmodule

// File: rtl/data_unit.sv
module data_unit
  import seq_pkg::*;
#(
  parameter int         DW       = 8,
  parameter logic [7:0] PAIR_OPC = 8'h11
) (
  input  logic          clk,
  input  logic          rst,
  input  mcyc_e         mc,
  input  logic          ev_t1_hi,
  input  logic          ev_t3_lo,
  input  logic          ev_t3_hi,
  input  logic          ev_last_hi,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] tmp,
  output logic          is_pair,
  output logic          wr_lo,
  output logic          wr_hi
);

  logic hi_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir         <= '0;
      tmp        <= '0;
      hi_pending <= 1'b0;
    end else begin
      if (ev_t3_lo) begin
        if (mc == MC_FETCH) ir  <= din;
        else                tmp <= din;
      end
      if (ev_last_hi && mc == MC_DATA2)
        hi_pending <= 1'b1;
      else if (ev_t3_hi && mc == MC_FETCH)
        hi_pending <= 1'b0;
    end
  end

  assign is_pair = (ir == DW'(PAIR_OPC));
  assign wr_lo   = ev_t1_hi && (mc == MC_DATA2);
  assign wr_hi   = ev_t3_hi && (mc == MC_FETCH) && hi_pending;

endmodule

// File: rtl/imm_fetch_seq.sv
module imm_fetch_seq
  import seq_pkg::*;
#(
  parameter int         AW       = 16,
  parameter int         DW       = 8,
  parameter logic [7:0] PAIR_OPC = 8'h11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DW-1:0]      data_in,
  output logic [AW-1:0]      addr_out,
  output logic               addr_en,
  output logic               rd_en,
  output logic [AW-1:0]      pc_out,
  output logic [DW-1:0]      ir_out,
  output logic               wr_lo,
  output logic               wr_hi,
  output logic [DW-1:0]      wr_data,
  output logic [STATE_W-1:0] state_code
);

  mcyc_e             mc;
  logic [TIDX_W-1:0] tix;
  logic              ph;
  logic              ev_t1, ev_t1_hi, ev_t2_hi, ev_t3_lo, ev_t3_hi, ev_last_hi;
  logic              rd_window, is_pair;
  logic [DW-1:0]     tmp;

  phase_timer u_timer (
    .clk(clk), .rst(rst), .is_pair(is_pair),
    .mc(mc), .tix(tix), .ph(ph),
    .ev_t1(ev_t1), .ev_t1_hi(ev_t1_hi), .ev_t2_hi(ev_t2_hi),
    .ev_t3_lo(ev_t3_lo), .ev_t3_hi(ev_t3_hi), .ev_last_hi(ev_last_hi),
    .rd_window(rd_window)
  );

  addr_unit #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst),
    .ev_last_hi(ev_last_hi), .ev_t2_hi(ev_t2_hi),
    .pc(pc_out), .inc_latch(addr_out)
  );

  data_unit #(.DW(DW), .PAIR_OPC(PAIR_OPC)) u_data (
    .clk(clk), .rst(rst), .mc(mc),
    .ev_t1_hi(ev_t1_hi), .ev_t3_lo(ev_t3_lo), .ev_t3_hi(ev_t3_hi),
    .ev_last_hi(ev_last_hi), .din(data_in),
    .ir(ir_out), .tmp(tmp), .is_pair(is_pair),
    .wr_lo(wr_lo), .wr_hi(wr_hi)
  );

  assign addr_en    = ev_t1;
  assign rd_en      = rd_window;
  assign wr_data    = alu_pass(tmp);
  assign state_code = pack_state(mc, tix, ph);

endmodule

// File: rtl/imm_fetch_seq_chk.sv
module imm_fetch_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_out,
  input logic          addr_en,
  input logic          rd_en,
  input logic [AW-1:0] pc_out,
  input logic          wr_lo,
  input logic          wr_hi,
  input logic [4:0]    state_code
);

  AST_PHASE_RISE: assert property (@(posedge clk) disable iff (rst)
    !state_code[0] |=> state_code[0]); // R2
  AST_PHASE_FALL: assert property (@(posedge clk) disable iff (rst)
    state_code[0] |=> !state_code[0]); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (addr_en && $past(addr_en)) |-> $stable(addr_out)); // R4
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_out) |-> (pc_out == $past(addr_out) + AW'(1))); // R5
  AST_ADDR_IN_READ: assert property (@(posedge clk) disable iff (rst)
    addr_en |-> rd_en); // R6
  AST_LO_SLOT: assert property (@(posedge clk) disable iff (rst)
    wr_lo |-> (state_code == 5'b10001)); // R8
  AST_HI_SLOT: assert property (@(posedge clk) disable iff (rst)
    wr_hi |-> (state_code == 5'b00101)); // R9
  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_lo && wr_hi)); // R10

endmodule

bind imm_fetch_seq imm_fetch_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .addr_out(addr_out), .addr_en(addr_en),
  .rd_en(rd_en), .pc_out(pc_out), .wr_lo(wr_lo), .wr_hi(wr_hi),
  .state_code(state_code)
);

// File: tb/test_imm_fetch_seq.sv
`timescale 1ns/1ps
module test_imm_fetch_seq;

  localparam logic [7:0] OPC = 8'h11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  data_in;
  logic [15:0] addr_out, pc_out;
  logic        addr_en, rd_en, wr_lo, wr_hi;
  logic [7:0]  ir_out, wr_data;
  logic [4:0]  state_code;

  logic [7:0] mem [0:63];
  int prog_len;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  imm_fetch_seq i_imm_fetch_seq (
    .clk(clk), .rst(rst), .data_in(data_in), .addr_out(addr_out),
    .addr_en(addr_en), .rd_en(rd_en), .pc_out(pc_out), .ir_out(ir_out),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .state_code(state_code)
  );

  always_comb data_in = (addr_out < 16'd64) ? mem[addr_out[5:0]] : 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One machine cycle, checked at every negedge; ends after the cycle's last clock
  task automatic mcycle(input int mc, input logic [15:0] a, input bit pend,
                        input logic [7:0] hib, input logic [7:0] lob);
    int tmax;
    tmax = (mc == 0) ? 4 : 3;
    for (int t = 1; t <= tmax; t++) begin
      for (int ph = 0; ph < 2; ph++) begin
        logic [4:0] exp_sc;
        bit exp_lo, exp_hi;
        exp_sc = {2'(mc), 2'(t - 1), 1'(ph)};
        chk(state_code == exp_sc, "R2/R3 state_code", state_code, exp_sc);
        chk(addr_en == (t == 1), "R4 addr_en", addr_en, (t == 1));
        if (t == 1) chk(addr_out == a, "R4 addr_out", addr_out, a);
        chk(pc_out == ((t >= 3) ? a + 16'd1 : a), "R5 pc_out", pc_out,
            (t >= 3) ? a + 16'd1 : a);
        chk(rd_en == (t <= 3), "R6 rd_en", rd_en, (t <= 3));
        if (mc == 0 && t == 4) chk(ir_out == mem[a[5:0]], "R7 ir_out", ir_out, mem[a[5:0]]);
        exp_lo = (mc == 2) && (t == 1) && (ph == 1);
        exp_hi = (mc == 0) && (t == 3) && (ph == 1) && pend;
        chk(wr_lo == exp_lo, "R8 wr_lo", wr_lo, exp_lo);
        chk(wr_hi == exp_hi, "R9 wr_hi", wr_hi, exp_hi);
        if (exp_lo) chk(wr_data == lob, "R8 wr_data", wr_data, lob);
        if (exp_hi) chk(wr_data == hib, "R9 wr_data", wr_data, hib);
        chk(!(wr_lo && wr_hi), "R10 exclusive", {wr_lo, wr_hi}, 2'b00);
        @(negedge clk);
      end
    end
  endtask

  task automatic run_program();
    logic [15:0] a;
    bit pend;
    logic [7:0] hib;
    a = 16'd0; pend = 0; hib = 8'h00;
    while (int'(a) < prog_len) begin
      mcycle(0, a, pend, hib, 8'h00);
      if (mem[a[5:0]] == OPC) begin
        mcycle(1, a + 16'd1, 0, 8'h00, 8'h00);
        mcycle(2, a + 16'd2, 0, 8'h00, mem[a[5:0] + 6'd1]);
        hib  = mem[a[5:0] + 6'd2];
        pend = 1;
        a    = a + 16'd3;
      end else begin
        pend = 0;
        a    = a + 16'd1;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(state_code == 5'd0, "R1 state_code", state_code, 0);
    chk(pc_out == 16'd0, "R1 pc_out", pc_out, 0);
    chk(addr_out == 16'd0, "R1 addr_out", addr_out, 0);
    chk(!wr_lo && !wr_hi, "R1 strobes", {wr_lo, wr_hi}, 0);
    rst = 1'b0;
  endtask

  initial begin
    int pos;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    pos = 0;
    for (int k = 0; k < 18; k++) begin
      if (k % 3 != 2) begin
        mem[pos]     = OPC;
        mem[pos + 1] = (k == 0) ? 8'h00 : 8'((k * 37 + 5) % 256);
        mem[pos + 2] = (k == 0) ? 8'hFF : 8'((k * 91 + 200) % 256);
        pos += 3;
      end else begin
        mem[pos] = 8'(k + 8'h40);
        pos += 1;
      end
    end
    prog_len = pos;

    @(negedge clk);
    do_reset();
    run_program();
    repeat (7) @(negedge clk);
    do_reset();
    run_program();

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #500us;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule